// File: doc/BRIEF.md
# Leaky-Bucket Trigger Burst Limiter

This block keeps a running count of recent triggers and reports when a burst has grown too large. Every accepted trigger pulse drops one token into a bucket. While the bucket holds tokens, a timer removes one token each time a programmable leak interval runs out. The interval is counted in coarse steps, each a fixed number of clock cycles (400 by default, which makes one step 10 µs at a 25 ns clock). The step count is a 16-bit setting.

When the number of tokens reaches the programmed limit, the block raises an over-burst flag. A separate busy generator uses this flag to hold off further triggers. A limit of zero switches the limiter off, and the flag then stays low. The current token count is also brought out for debug. The flag follows the level in the same cycle, so it drops as soon as a leak brings the level under the limit.

Top module: `burst_interlock`

## Requirements
- R1: A trigger pulse in a cycle with no leak event raises `level_o` by exactly one at the next clock edge.
- R2: `level_o` saturates at 63. A trigger seen at level 63 leaves it at 63.
- R3: While the level is non-zero and `leak_steps_i` = N > 0, one token is removed every N×STEP_CYCLES cycles. The first interval starts at the edge where the level leaves zero, and the timer reloads after every leak. Triggers that arrive in between do not restart it.
- R4: With `leak_steps_i` = 0 no token is ever removed.
- R5: With `burst_max_i` = S ≠ 0, `over_burst_o` is 1 exactly while `level_o` ≥ S.
- R6: With `burst_max_i` = 0, `over_burst_o` stays 0 at every level, including 63.
- R7: `over_burst_o` falls in the same cycle that a leak brings `level_o` below the limit.
- R8: A trigger in the same cycle as a leak event leaves `level_o` unchanged.
- R9: An active-low `rst_n` asynchronously clears the level, the flag and the leak timer.
- R10: At level 0 the leak timer is idle. The level never goes below 0, and no leak happens until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Accepted trigger, one pulse per cycle counted |
| burst_max_i | input | 6 | Burst limit; 0 disables the flag |
| leak_steps_i | input | 16 | Leak interval in steps of STEP_CYCLES clocks; 0 stops draining |
| over_burst_o | output | 1 | Bucket level has reached the limit |
| level_o | output | 6 | Current bucket level (debug) |

## Verification
The assertions assume that `trig_i` is a clean synchronous level sampled once per edge. They also assume that `burst_max_i` and `leak_steps_i` stay steady between the points where the bench changes them. The check that relates a falling flag to a leak event is only made when the limit held still across that edge. The bench changes the settings only while reset is held or while the bucket is idle, and it holds all inputs low during reset. It drives every input at the falling clock edge, so each rising edge sees settled values.

// File: rtl/lbi_pkg.sv
package lbi_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } lvl_act_e;

  // A trigger and a leak together cancel out.
  function automatic lvl_act_e pick_act(input logic add, input logic drain);
    if (add && !drain)      return ACT_INC;
    else if (drain && !add) return ACT_DEC;
    else                    return ACT_HOLD;
  endfunction

endpackage

// File: rtl/lbi_step_timer.sv
module lbi_step_timer #(
  parameter int STEP_CYCLES = 400,
  parameter int LEAK_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LEAK_W-1:0] leak_steps,
  output logic              tick
);
  localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic              step_done;
  logic [LEAK_W-1:0] stp_q;

  function automatic logic interval_done(input logic [LEAK_W-1:0] cnt,
                                         input logic [LEAK_W-1:0] lim);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  endfunction

  generate
    if (STEP_CYCLES > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign step_done = (pre_q == PRE_W'(STEP_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (!run || tick)   pre_q <= '0;
        else if (step_done)      pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign step_done = 1'b1;
    end
  endgenerate

  assign tick = run && step_done && interval_done(stp_q, leak_steps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stp_q <= '0;
    else if (!run || tick)   stp_q <= '0;
    else if (step_done)      stp_q <= stp_q + 1'b1;
  end

endmodule

// File: rtl/lbi_bucket.sv
module lbi_bucket #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic             drain,
  output logic [LVL_W-1:0] level
);
  import lbi_pkg::*;

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  lvl_act_e         act;
  logic [LVL_W-1:0] level_d;

  function automatic logic [LVL_W-1:0] next_level(input logic [LVL_W-1:0] cur,
                                                  input lvl_act_e a);
    case (a)
      ACT_INC: return (cur == LVL_MAX) ? cur : cur + 1'b1;
      ACT_DEC: return (cur == '0) ? cur : cur - 1'b1;
      default: return cur;
    endcase
  endfunction

  assign act     = pick_act(add, drain);
  assign level_d = next_level(level, act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_d;
  end

endmodule

// File: rtl/lbi_limit.sv
module lbi_limit #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] limit,
  output logic             over
);
  function automatic logic limit_hit(input logic [LVL_W-1:0] lv,
                                     input logic [LVL_W-1:0] lim);
    return (lim != '0) && (lv >= lim);
  endfunction

  assign over = limit_hit(level, limit);

endmodule

// File: rtl/burst_interlock.sv
module burst_interlock #(
  parameter int STEP_CYCLES = 400,
  parameter int LVL_W       = 6,
  parameter int LEAK_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [LVL_W-1:0]  burst_max_i,
  input  logic [LEAK_W-1:0] leak_steps_i,
  output logic              over_burst_o,
  output logic [LVL_W-1:0]  level_o
);
  logic             leak_run;
  logic             leak_tick;
  logic [LVL_W-1:0] level;

  assign leak_run = (level != '0) && (leak_steps_i != '0);

  lbi_step_timer #(
    .STEP_CYCLES (STEP_CYCLES),
    .LEAK_W      (LEAK_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (leak_run),
    .leak_steps (leak_steps_i),
    .tick       (leak_tick)
  );

  lbi_bucket #(
    .LVL_W (LVL_W)
  ) u_bucket (
    .clk   (clk),
    .rst_n (rst_n),
    .add   (trig_i),
    .drain (leak_tick),
    .level (level)
  );

  lbi_limit #(
    .LVL_W (LVL_W)
  ) u_limit (
    .level (level),
    .limit (burst_max_i),
    .over  (over_burst_o)
  );

  assign level_o = level;

endmodule

// File: rtl/lbi_checker.sv
module lbi_checker #(
  parameter int LVL_W  = 6,
  parameter int LEAK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic [LVL_W-1:0]  burst_max_i,
  input logic [LEAK_W-1:0] leak_steps_i,
  input logic              over_burst_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              leak_tick
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && !leak_tick && level_o != LVL_MAX |=> level_o == $past(level_o) + 1'b1);

  assert_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && level_o == LVL_MAX |=> level_o == LVL_MAX);

  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    leak_tick && !trig_i |=> level_o == $past(level_o) - 1'b1);

  assert_noleak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    leak_steps_i == '0 |-> !leak_tick);

  assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_max_i == '0 |-> !over_burst_o);

  assert_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(over_burst_o) && $stable(burst_max_i) |-> $past(leak_tick));

  assert_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && leak_tick |=> $stable(level_o));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    leak_tick |-> level_o != '0);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i && !leak_tick |=> $stable(level_o));

endmodule

bind burst_interlock lbi_checker #(
  .LVL_W  (LVL_W),
  .LEAK_W (LEAK_W)
) u_lbi_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .burst_max_i  (burst_max_i),
  .leak_steps_i (leak_steps_i),
  .over_burst_o (over_burst_o),
  .level_o      (level_o),
  .leak_tick    (leak_tick)
);

// File: tb/test_burst_interlock.sv
`timescale 1ns/1ps
module test_burst_interlock;
  localparam int STEP = 10;
  localparam int NV   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [5:0]  bmax = '0;
  logic [15:0] lsteps = '0;
  logic        over;
  logic [5:0]  level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  burst_interlock #(.STEP_CYCLES(STEP)) i_burst_interlock (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig),
    .burst_max_i  (bmax),
    .leak_steps_i (lsteps),
    .over_burst_o (over),
    .level_o      (level)
  );

  // Vectors with draining off: limit, trigger count, expected level, expected flag.
  localparam int V_MAX [NV] = '{3, 3, 0, 63, 63, 1, 0, 40};
  localparam int V_N   [NV] = '{2, 3, 10, 62, 70, 0, 70, 45};
  localparam int V_LVL [NV] = '{2, 3, 10, 62, 63, 0, 63, 45};
  localparam int V_FLG [NV] = '{0, 1, 0, 0, 1, 0, 0, 1};

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trig  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    if (n > 0) begin
      trig = 1'b1;
      repeat (n) @(negedge clk);
      trig = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    check("R9", "level in reset", level, 0);
    check("R9", "flag in reset", over, 0);

    // Table walk: R1, R2, R5, R6
    for (int i = 0; i < NV; i++) begin
      lsteps = 16'd0;
      bmax   = 6'(V_MAX[i]);
      do_reset();
      pulse(V_N[i]);
      check(V_LVL[i] == 63 ? "R2" : "R1", $sformatf("vec%0d level", i), level, V_LVL[i]);
      check(V_MAX[i] == 0 ? "R6" : "R5", $sformatf("vec%0d flag", i), over, V_FLG[i]);
    end

    // R4: no draining with zero leak setting
    bmax = 6'd2; lsteps = 16'd0;
    do_reset();
    pulse(4);
    repeat (200) @(negedge clk);
    check("R4", "level held", level, 4);

    // R9: asynchronous reset mid-run
    rst_n = 1'b0;
    #3;
    check("R9", "level async clear", level, 0);
    check("R9", "flag async clear", over, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R7/R8/R10: leak every 2*STEP = 20 cycles
    bmax = 6'd3; lsteps = 16'd2;
    do_reset();
    pulse(3);                      // edges E0..E2, now after E2
    repeat (17) @(negedge clk);    // after E19
    check("R3", "level before first leak", level, 3);
    check("R5", "flag at limit", over, 1);
    @(negedge clk);                // after E20
    check("R3", "level after first leak", level, 2);
    check("R7", "flag cleared by leak", over, 0);
    repeat (19) @(negedge clk);    // after E39
    trig = 1'b1;                   // sampled at E40 with a leak
    @(negedge clk);
    trig = 1'b0;
    check("R8", "trigger plus leak", level, 2);
    repeat (19) @(negedge clk);    // after E59
    check("R3", "level before reloaded leak", level, 2);
    @(negedge clk);                // after E60
    check("R3", "level after reloaded leak", level, 1);
    repeat (20) @(negedge clk);    // after E80
    check("R3", "level drained", level, 0);
    repeat (47) @(negedge clk);
    check("R10", "no leak below zero", level, 0);
    pulse(1);                      // edge F0
    repeat (19) @(negedge clk);    // after F19
    check("R10", "fresh interval start", level, 1);
    @(negedge clk);                // after F20
    check("R3", "fresh interval leak", level, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule